// File: doc/BRIEF.md
# Static RAM Write-Cycle Sequencer

This block sits on the host side of an asynchronous static RAM that latches its address and one chip-select on the falling edge of its enable strobe. It accepts write requests through a valid/ready handshake. Each request carries an address and a data word. For each request the block steps the RAM control strobes through a fixed phase order: address setup, latch, write open, data drive, data hold and precharge. The data bus is shared with the RAM's outputs, so the block drives it only through an output-enable that an external tristate buffer uses. The length of every phase is a parameter in clock cycles, and each of these parameters must be at least 1.

Two modes are selected by a level input. In single mode every write raises the write strobe again before the next write begins. In burst mode a new request may be accepted in the last cycle of the hold phase. The write strobe then stays low into the next write, and data timing is referenced only to the rising edge of the enable and select strobes. Because the RAM outputs stay disabled through such a chain, a chained write skips the output-disable wait.

Top module: `sram_wr_seq`

## Requirements
- R1: After reset and whenever the sequencer is idle, `mem_en_n`, `mem_sel_n`, `mem_wr_n` and `mem_cs_hi` are 1, `dq_oe` is 0, `dq_out` is 0 and `wr_ready` is 1.
- R2: Before `mem_en_n` falls, the requested address sits on `mem_addr` with `mem_cs_hi` low and `mem_en_n` high for at least T_ASU cycles. The address and `mem_cs_hi` = 0 are stable across the falling edge. Addresses reach the RAM in request order.
- R3: `mem_sel_n` and `mem_wr_n` go low together exactly one cycle after `mem_en_n` falls. In an unchained write, `dq_oe` rises only after `mem_wr_n` has been low for T_ODLY cycles.
- R4: The requested word is driven with `dq_oe` = 1 for at least T_DSU cycles before `mem_en_n` and `mem_sel_n` rise together. It stays driven unchanged for exactly T_DHD cycles after that rise. Whenever `dq_oe` is 0, `dq_out` is 0.
- R5: `mem_wr_n` is low in the cycle before, and the cycle of, every rise of `mem_en_n`.
- R6: In burst mode, a request accepted in the last hold cycle keeps `mem_wr_n` low continuously into the next write. A chain of N writes therefore has N falls of `mem_en_n` and exactly one rise of `mem_wr_n`. In single mode, every write raises `mem_wr_n` once.
- R7: Between a rise of `mem_en_n` and its next fall, `mem_en_n` stays high for at least T_PRE + T_ASU cycles.
- R8: `dq_oe` is never 1 while `mem_wr_n` is 1.
- R9: `wr_ready` is 1 only when idle, or in the last hold cycle while `burst_mode` = 1. Both `mem_en_n` and `mem_sel_n` are high in either case.
- R10: Counting from the cycle after acceptance, `wr_ready` returns exactly T_ASU+T_ODLY+T_DSU+T_DHD+T_PRE+2 cycles later for a single write. It returns T_ASU+1+T_ODLY+T_DSU+T_DHD cycles later for the first write of a burst, and T_PRE+T_ASU+T_DSU+T_DHD+2 cycles later for a chained write (12, 9 and 10 with the defaults).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_mode | input | 1 | 1 = chain writes with the write strobe held low |
| wr_valid | input | 1 | Request present |
| wr_ready | output | 1 | Request can be taken this cycle |
| wr_addr | input | ADDR_W | Request address |
| wr_data | input | DATA_W | Request data word |
| mem_en_n | output | 1 | RAM enable strobe, address latched on fall |
| mem_sel_n | output | 1 | RAM select, active low |
| mem_cs_hi | output | 1 | Latched chip select, must be low at latch |
| mem_wr_n | output | 1 | RAM write strobe, active low |
| mem_addr | output | ADDR_W | RAM address |
| dq_out | output | DATA_W | Data toward the shared bus |
| dq_oe | output | 1 | Bus driver enable, 0 = high impedance |

## Verification
The bench goes after the data window around the rise of the enable strobe. A design that released the bus too early would lose the hold count, and one that ended the write with the wrong strobe would show the write strobe high at that edge. It drives burst chains with back-to-back requests and counts write-strobe rises, so a design that lifted the strobe between chained writes, or that let the chain wait for the output-disable time, shows an extra rise or a wrong ready latency. Addresses at the extremes of the range and the all-zero and all-one words show a swapped or stale request register. Random mode switches between groups show whether ready is leaked outside the idle and hold windows.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ASU   = 3'd1,
    ST_LATCH = 3'd2,
    ST_OPEN  = 3'd3,
    ST_DRIVE = 3'd4,
    ST_HOLD  = 3'd5,
    ST_PRE   = 3'd6
  } wr_state_e;

  typedef struct packed {
    logic en_n;
    logic sel_n;
    logic cs_hi;
    logic wr_n;
    logic oe;
  } pin_lvl_t;

  // Duration in cycles of a phase; a chained write opens in one cycle.
  function automatic int unsigned phase_cycles(
    input wr_state_e   st,
    input logic        chained,
    input int unsigned t_asu,
    input int unsigned t_odly,
    input int unsigned t_dsu,
    input int unsigned t_dhd,
    input int unsigned t_pre
  );
    int unsigned n;
    case (st)
      ST_ASU:   n = t_asu;
      ST_LATCH: n = 1;
      ST_OPEN:  n = chained ? 1 : t_odly;
      ST_DRIVE: n = t_dsu;
      ST_HOLD:  n = t_dhd;
      ST_PRE:   n = t_pre;
      default:  n = 1;
    endcase
    return n;
  endfunction

  function automatic int unsigned max_of5(
    input int unsigned a, input int unsigned b, input int unsigned c,
    input int unsigned d, input int unsigned e
  );
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    return m;
  endfunction

  // Strobe levels for each phase; chain keeps the write strobe low.
  function automatic pin_lvl_t pin_levels(input wr_state_e st, input logic chained);
    pin_lvl_t p;
    p = '{en_n: 1'b1, sel_n: 1'b1, cs_hi: 1'b1, wr_n: 1'b1, oe: 1'b0};
    case (st)
      ST_ASU:   begin p.cs_hi = 1'b0; p.wr_n = ~chained; end
      ST_LATCH: begin p.cs_hi = 1'b0; p.en_n = 1'b0; p.wr_n = ~chained; end
      ST_OPEN:  begin p.cs_hi = 1'b0; p.en_n = 1'b0; p.sel_n = 1'b0; p.wr_n = 1'b0; end
      ST_DRIVE: begin p.cs_hi = 1'b0; p.en_n = 1'b0; p.sel_n = 1'b0; p.wr_n = 1'b0; p.oe = 1'b1; end
      ST_HOLD:  begin p.wr_n = 1'b0; p.oe = 1'b1; end
      ST_PRE:   begin p.wr_n = ~chained; end
      default:  p.wr_n = 1'b1;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_wr_timer.sv
module sram_wr_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_wr_ctrl.sv
module sram_wr_ctrl
  import sram_wr_pkg::*;
#(
  parameter int T_ASU  = 2,
  parameter int T_ODLY = 2,
  parameter int T_DSU  = 3,
  parameter int T_DHD  = 1,
  parameter int T_PRE  = 2,
  parameter int CNT_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             burst_mode,
  input  logic             wr_valid,
  input  logic             phase_done,
  output wr_state_e        st,
  output logic             chained,
  output logic             accept,
  output logic             ready,
  output logic             hold_last,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val
);
  wr_state_e st_q, st_d;
  logic      chain_q, chain_d;

  assign hold_last = (st_q == ST_HOLD) && phase_done;
  assign ready     = (st_q == ST_IDLE) || (hold_last && burst_mode);
  assign accept    = ready && wr_valid;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (accept)     st_d = ST_ASU;
      ST_ASU:   if (phase_done) st_d = ST_LATCH;
      ST_LATCH: if (phase_done) st_d = ST_OPEN;
      ST_OPEN:  if (phase_done) st_d = ST_DRIVE;
      ST_DRIVE: if (phase_done) st_d = ST_HOLD;
      ST_HOLD:  if (phase_done) st_d = ST_PRE;
      ST_PRE:   if (phase_done) st_d = chain_q ? ST_ASU : ST_IDLE;
      default:                  st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    chain_d = chain_q;
    if ((st_q == ST_IDLE) && accept) chain_d = 1'b0;
    else if (hold_last)              chain_d = accept;
  end

  assign tmr_load = (st_d != st_q);
  assign tmr_val  = CNT_W'(phase_cycles(st_d, chain_d, T_ASU, T_ODLY, T_DSU, T_DHD, T_PRE) - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      chain_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      chain_q <= chain_d;
    end
  end

  assign st      = st_q;
  assign chained = chain_q;
endmodule

// File: rtl/sram_wr_pins.sv
module sram_wr_pins
  import sram_wr_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  wr_state_e          st,
  input  logic               chained,
  input  logic [DATA_W-1:0]  word,
  output logic               mem_en_n,
  output logic               mem_sel_n,
  output logic               mem_cs_hi,
  output logic               mem_wr_n,
  output logic               dq_oe,
  output logic [DATA_W-1:0]  dq_out
);
  pin_lvl_t lvl;

  assign lvl       = pin_levels(st, chained);
  assign mem_en_n  = lvl.en_n;
  assign mem_sel_n = lvl.sel_n;
  assign mem_cs_hi = lvl.cs_hi;
  assign mem_wr_n  = lvl.wr_n;
  assign dq_oe     = lvl.oe;

  for (genvar b = 0; b < DATA_W; b++) begin : g_gate
    assign dq_out[b] = lvl.oe & word[b];
  end
endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
  import sram_wr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4,
  parameter int T_ASU  = 2,
  parameter int T_ODLY = 2,
  parameter int T_DSU  = 3,
  parameter int T_DHD  = 1,
  parameter int T_PRE  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              burst_mode,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              mem_en_n,
  output logic              mem_sel_n,
  output logic              mem_cs_hi,
  output logic              mem_wr_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  localparam int MAX_T = max_of5(T_ASU, T_ODLY, T_DSU, T_DHD, T_PRE);
  localparam int CNT_W = $clog2(MAX_T + 1) + 1;

  wr_state_e          st;
  logic               chained, accept, hold_last, phase_done, tmr_load;
  logic [CNT_W-1:0]   tmr_val;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  data_q;

  sram_wr_ctrl #(
    .T_ASU(T_ASU), .T_ODLY(T_ODLY), .T_DSU(T_DSU),
    .T_DHD(T_DHD), .T_PRE(T_PRE), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .burst_mode(burst_mode), .wr_valid(wr_valid),
    .phase_done(phase_done), .st(st), .chained(chained), .accept(accept),
    .ready(wr_ready), .hold_last(hold_last), .tmr_load(tmr_load), .tmr_val(tmr_val)
  );

  sram_wr_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(phase_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      addr_q <= wr_addr;
      data_q <= wr_data;
    end
  end

  assign mem_addr = addr_q;

  sram_wr_pins #(.DATA_W(DATA_W)) u_pins (
    .st(st), .chained(chained), .word(data_q),
    .mem_en_n(mem_en_n), .mem_sel_n(mem_sel_n), .mem_cs_hi(mem_cs_hi),
    .mem_wr_n(mem_wr_n), .dq_oe(dq_oe), .dq_out(dq_out)
  );
endmodule

// File: rtl/sram_wr_seq_chk.sv
module sram_wr_seq_chk
  import sram_wr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input wr_state_e         st,
  input logic              accept,
  input logic              wr_ready,
  input logic              mem_en_n,
  input logic              mem_sel_n,
  input logic              mem_cs_hi,
  input logic              mem_wr_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] dq_out,
  input logic              dq_oe
);
  a_r1_idle_levels: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> (mem_en_n && mem_sel_n && mem_wr_n && mem_cs_hi && !dq_oe && wr_ready));

  a_r2_latch_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_en_n) |-> (!mem_cs_hi && $stable(mem_addr) && $stable(mem_cs_hi)));

  a_r3_oe_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> (!mem_wr_n && $past(!mem_wr_n)));

  a_r4_word_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && $past(dq_oe)) |-> $stable(dq_out));

  a_r4_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (dq_out == '0));

  a_r5_wr_low_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_en_n) |-> (!mem_wr_n && $past(!mem_wr_n)));

  a_r6_chain_keeps_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !mem_wr_n) |=> !mem_wr_n);

  a_r8_oe_needs_wr: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !mem_wr_n);

  a_r9_ready_window: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (mem_en_n && mem_sel_n));
endmodule

bind sram_wr_seq sram_wr_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .accept(accept), .wr_ready(wr_ready),
  .mem_en_n(mem_en_n), .mem_sel_n(mem_sel_n), .mem_cs_hi(mem_cs_hi),
  .mem_wr_n(mem_wr_n), .mem_addr(mem_addr), .dq_out(dq_out), .dq_oe(dq_oe)
);

// File: tb/sram_wr_seq_test.sv
module sram_wr_seq_test;
  localparam int AW = 8, DW = 4;
  localparam int TA = 2, TO = 2, TS = 3, TH = 1, TP = 2;

  logic clk = 0, rst_n = 0, burst_mode = 0, wr_valid = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic wr_ready, mem_en_n, mem_sel_n, mem_cs_hi, mem_wr_n, dq_oe;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] dq_out;

  always #4 clk = ~clk;

  sram_wr_seq #(.ADDR_W(AW), .DATA_W(DW), .T_ASU(TA), .T_ODLY(TO),
                .T_DSU(TS), .T_DHD(TH), .T_PRE(TP)) uut (
    .clk(clk), .rst_n(rst_n), .burst_mode(burst_mode), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .mem_en_n(mem_en_n), .mem_sel_n(mem_sel_n), .mem_cs_hi(mem_cs_hi),
    .mem_wr_n(mem_wr_n), .mem_addr(mem_addr), .dq_out(dq_out), .dq_oe(dq_oe));

  int n_cmp = 0, n_bad = 0, cyc = 0, last_acc = 0;
  int wr_rises = 0, en_falls = 0, viol_oe = 0, viol_rdy = 0;
  bit done = 0;
  logic [AW-1:0] qa[$];
  logic [DW-1:0] qd[$];
  logic [DW-1:0] cur_d = '0;

  function automatic int lat_single();  return TA + TO + TS + TH + TP + 2; endfunction
  function automatic int lat_first();   return TA + 1 + TO + TS + TH;      endfunction
  function automatic int lat_chain();   return TP + TA + TS + TH + 2;      endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Protocol monitor, sampled on the falling edge
  logic p_e = 1, p_s1 = 1, p_w = 1, p_oe = 0, p_s2 = 1;
  logic [AW-1:0] p_a = '0;
  int e_hi = 0, e_lo = 0, w_lo = 0, oe_run = 0, hold_run = 0, a_run = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      int old_e_hi, old_hold;
      old_e_hi = e_hi;
      old_hold = hold_run;
      a_run    = (mem_addr == p_a && mem_cs_hi == p_s2) ? a_run + 1 : 1;
      e_hi     = mem_en_n ? e_hi + 1 : 0;
      e_lo     = mem_en_n ? 0 : e_lo + 1;
      w_lo     = mem_wr_n ? 0 : w_lo + 1;
      oe_run   = dq_oe ? oe_run + 1 : 0;
      hold_run = (dq_oe && mem_en_n) ? hold_run + 1 : 0;
      if (dq_oe && mem_wr_n) viol_oe++;
      if (wr_ready && !(mem_en_n && mem_sel_n)) viol_rdy++;
      if (!p_w && mem_wr_n) wr_rises++;
      if (p_e && !mem_en_n) begin
        en_falls++;
        chk(qa.size() > 0, "R2 queue", qa.size(), 1);
        if (qa.size() > 0) begin
          logic [AW-1:0] ea;
          ea = qa.pop_front();
          cur_d = qd.pop_front();
          chk(mem_addr == ea, "R2 addr", mem_addr, ea);
        end
        chk(!mem_cs_hi && !p_s2, "R2 cs low", mem_cs_hi, 0);
        chk(a_run >= TA + 1, "R2 setup", a_run, TA + 1);
        chk(old_e_hi >= TP + TA, "R7 en high", old_e_hi, TP + TA);
      end
      if (p_s1 && !mem_sel_n)
        chk(!mem_wr_n && e_lo == 2, "R3 open", e_lo, 2);
      if (!p_oe && dq_oe)
        chk(w_lo >= TO + 1, "R3 disable wait", w_lo, TO + 1);
      if (!p_e && mem_en_n) begin
        chk(mem_sel_n, "R4 sel rise", mem_sel_n, 1);
        chk(!mem_wr_n && !p_w, "R5 wr low", mem_wr_n, 0);
        chk(dq_out == cur_d, "R4 word", dq_out, cur_d);
        chk(oe_run >= TS + 1, "R4 setup", oe_run, TS + 1);
      end
      if (p_oe && !dq_oe) begin
        chk(old_hold == TH, "R4 hold", old_hold, TH);
        chk(dq_out == '0, "R4 released", dq_out, 0);
      end
      p_e = mem_en_n; p_s1 = mem_sel_n; p_w = mem_wr_n; p_oe = dq_oe;
      p_s2 = mem_cs_hi; p_a = mem_addr;
    end
  end

  task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d, input int lat);
    wr_valid = 1; wr_addr = a; wr_data = d;
    while (!wr_ready) @(negedge clk);
    if (lat != 0) chk(cyc - last_acc == lat, "R10 latency", cyc - last_acc, lat);
    last_acc = cyc;
    qa.push_back(a); qd.push_back(d);
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic drain();
    while (!(wr_ready && mem_wr_n)) @(negedge clk);
  endtask

  task automatic idle_check(input string tag);
    chk(mem_en_n && mem_sel_n && mem_wr_n && mem_cs_hi, {tag, " strobes"},
        {mem_en_n, mem_sel_n, mem_wr_n, mem_cs_hi}, 15);
    chk(!dq_oe && dq_out == '0 && wr_ready, {tag, " bus/ready"}, {dq_oe, wr_ready}, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int w0, f0;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    idle_check("R1 reset");

    // R10 single-mode latency, extreme address/data values
    burst_mode = 0;
    w0 = wr_rises;
    push(8'h00, 4'h0, 0);
    push(8'hFF, 4'hF, lat_single());
    drain();
    idle_check("R1 after single");
    chk(wr_rises - w0 == 2, "R6 single rises", wr_rises - w0, 2);

    // R6 burst chain with back-to-back requests
    burst_mode = 1;
    w0 = wr_rises; f0 = en_falls;
    push(8'hA5, 4'h5, 0);
    push(8'h5A, 4'hA, lat_first());
    push(8'hFF, 4'h0, lat_chain());
    drain();
    chk(wr_rises - w0 == 1, "R6 burst rises", wr_rises - w0, 1);
    chk(en_falls - f0 == 3, "R6 burst falls", en_falls - f0, 3);

    // Random groups
    for (int g = 0; g < 14; g++) begin
      int n;
      burst_mode = $urandom_range(0, 1);
      n = $urandom_range(1, 4);
      w0 = wr_rises; f0 = en_falls;
      for (int k = 0; k < n; k++)
        push(8'($urandom), 4'($urandom), 0);
      drain();
      chk(en_falls - f0 == n, "R2 write count", en_falls - f0, n);
      chk(wr_rises - w0 == (burst_mode ? 1 : n), "R6 rises", wr_rises - w0,
          burst_mode ? 1 : n);
    end

    repeat (4) @(negedge clk);
    idle_check("R1 final");
    chk(viol_oe == 0, "R8 oe with wr high", viol_oe, 0);
    chk(viol_rdy == 0, "R9 ready window", viol_rdy, 0);
    chk(qa.size() == 0, "R2 all written", qa.size(), 0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule